// File: doc/BRIEF.md
# One-Shot Preset Down-Counter

This block counts down a batch of items exactly once per start event. A rising edge on the start (sync) input copies a staged preset value into a 32-bit count register and arms the counter. Every qualified pulse on the count input then removes one unit, but only while the count-enable input allows it. When the register reaches zero the counter parks and ignores further count pulses until the next start edge. A typical use is to raise an indication at the end of a batch of operations.

The sync and enable pins can each be switched off by configuration bits. A new preset is written into a shadow register at any time and is used only by the next start-triggered load, so a running batch is never disturbed. The count visible outside is not the live register: it is republished on a periodic tick, 1 ms in the intended system. A validity bit shows that at least one publication has happened. A sticky sync-reference flag records that a load has occurred, and software clears it with a rising edge on a command bit.

Top module: `oneshot_downcounter`

## Requirements
- R1: A rising edge on `sync_in`, when `cfg_sync_use` is 1, loads the shadow preset into the count register. `sync_in` is synchronised through two flip-flops and edge-detected internally, so one edge gives exactly one load.
- R2: Each rising edge on `count_in` decrements the count register by exactly one while counting is enabled and the register is nonzero.
- R3: While the register is zero, `count_in` pulses leave it at zero until the next load.
- R4: When `cfg_en_use` is 1 and `en_in` is low, count pulses are ignored and the value is held, but sync edges still reload the preset.
- R5: `run` is 1 after a load of a nonzero preset and falls to 0 when the register reaches zero. A load of preset 0 leaves `run` at 0.
- R6: `sync_ref_flag` is set by every load. It stays set until a rising edge of `sref_clear`, which clears it. If a load happens in the same cycle as that edge, the load wins.
- R7: With `cfg_sync_use` = 0, sync edges have no effect. With `cfg_en_use` = 0, the `en_in` pin is ignored and counting is always enabled.
- R8: `preset_we` writes `preset_data` into a shadow register. The write does not change a count in progress and takes effect only at the next load.
- R9: `count_out` changes only on a publish tick, which occurs once every `TICK_DIV` clock cycles. The first tick comes `TICK_DIV` cycles after reset is released.
- R10: After reset, `valid` is 0 and `count_out` reads 0. `valid` goes to 1 with the first publication and stays at 1.
- R11: If a sync edge and a count edge reach the counter in the same cycle, the load wins and no decrement is applied.
- R12: The full 32-bit range is supported: preset 4294967295 loads unchanged, and one pulse then gives 4294967294.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_in | input | 1 | Count pulse input (asynchronous) |
| sync_in | input | 1 | Start/reload input (asynchronous) |
| en_in | input | 1 | Count-enable level input (asynchronous) |
| cfg_sync_use | input | 1 | 1: obey `sync_in`; 0: ignore it |
| cfg_en_use | input | 1 | 1: obey `en_in`; 0: counting always enabled |
| preset_we | input | 1 | Write strobe for the shadow preset |
| preset_data | input | CNT_W | Preset value to stage |
| sref_clear | input | 1 | Command bit; its rising edge clears `sync_ref_flag` |
| count_out | output | CNT_W | Published count value |
| run | output | 1 | Down-count in progress |
| sync_ref_flag | output | 1 | Sticky: preset has been loaded and the count (re)started |
| valid | output | 1 | `count_out` holds published data |

## Verification
The hardest case to reach is a sync edge and a count edge landing in the same internal cycle. Both inputs pass through identical synchroniser chains, so the bench raises the two pins on the same clock edge, and their rising edges then reach the counter together. A second hard-to-observe case is the staged preset: the live register is only visible through the periodic publication. The bench therefore writes a new preset in the middle of a batch, and it waits several publish periods after each stimulus before it compares. This shows both that the running count continues undisturbed and that the next load takes the new value.

// File: rtl/os_pkg.sv
package os_pkg;
  localparam int OS_CNT_W_DEF = 32;
  localparam int OS_NUM_IN    = 3;
  localparam int OS_IDX_CNT   = 0;
  localparam int OS_IDX_SYNC  = 1;
  localparam int OS_IDX_EN    = 2;

  typedef struct packed {
    logic load;
    logic dec;
  } os_evt_t;
endpackage

// File: rtl/os_in_sync.sv
module os_in_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_lvl,
  output logic [N-1:0] q_rise
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= chain[STAGES-1];
  end

  assign q_lvl  = chain[STAGES-1];
  assign q_rise = chain[STAGES-1] & ~prev;

  a_r1_single_edge: assert property (@(posedge clk) disable iff (rst)
    |q_rise |=> ((q_rise & $past(q_rise)) == '0));
endmodule

// File: rtl/os_tick.sv
module os_tick #(
  parameter int DIV = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);

  logic [TW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= (div_cnt == LAST);
      if (div_cnt == LAST) div_cnt <= '0;
      else                 div_cnt <= div_cnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_chk
      a_r9_tick_spaced: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/os_core.sv
module os_core
  import os_pkg::*;
#(
  parameter int W = OS_CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  os_evt_t      evt,
  input  logic         cnt_en,
  input  logic [W-1:0] preset_shadow,
  output logic [W-1:0] cnt,
  output logic         run
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (evt.load) begin
      cnt <= preset_shadow;
      run <= |preset_shadow;
    end else if (evt.dec && cnt_en && run) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) run <= 1'b0;
    end
  end

  a_r1_load_value: assert property (@(posedge clk) disable iff (rst)
    evt.load |=> cnt == $past(preset_shadow));
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    !evt.load |=> (cnt == $past(cnt) || cnt == $past(cnt) - ONE));
  a_r3_zero_park: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !evt.load) |=> cnt == '0);
  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !evt.load) |=> $stable(cnt));
  a_r5_run_nonzero: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt != '0);
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |-> cnt == '0);
endmodule

// File: rtl/oneshot_downcounter.sv
module oneshot_downcounter
  import os_pkg::*;
#(
  parameter int CNT_W       = OS_CNT_W_DEF,
  parameter int TICK_DIV    = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_in,
  input  logic             sync_in,
  input  logic             en_in,
  input  logic             cfg_sync_use,
  input  logic             cfg_en_use,
  input  logic             preset_we,
  input  logic [CNT_W-1:0] preset_data,
  input  logic             sref_clear,
  output logic [CNT_W-1:0] count_out,
  output logic             run,
  output logic             sync_ref_flag,
  output logic             valid
);
  logic [OS_NUM_IN-1:0] pins, lvl, rise;
  logic [CNT_W-1:0]     shadow, live_cnt;
  logic                 pub_tick, clr_prev, clr_rise, cnt_en;
  os_evt_t              evt;

  assign pins[OS_IDX_CNT]  = count_in;
  assign pins[OS_IDX_SYNC] = sync_in;
  assign pins[OS_IDX_EN]   = en_in;

  os_in_sync #(.N(OS_NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pins), .q_lvl(lvl), .q_rise(rise)
  );

  os_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(pub_tick)
  );

  always_ff @(posedge clk) begin
    if (rst)            shadow <= '0;
    else if (preset_we) shadow <= preset_data;
  end

  assign evt.load = rise[OS_IDX_SYNC] & cfg_sync_use;
  assign evt.dec  = rise[OS_IDX_CNT];
  assign cnt_en   = cfg_en_use ? lvl[OS_IDX_EN] : 1'b1;

  os_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .evt(evt), .cnt_en(cnt_en),
    .preset_shadow(shadow), .cnt(live_cnt), .run(run)
  );

  always_ff @(posedge clk) begin
    if (rst) clr_prev <= 1'b0;
    else     clr_prev <= sref_clear;
  end
  assign clr_rise = sref_clear & ~clr_prev;

  always_ff @(posedge clk) begin
    if (rst)           sync_ref_flag <= 1'b0;
    else if (evt.load) sync_ref_flag <= 1'b1;
    else if (clr_rise) sync_ref_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_out <= '0;
      valid     <= 1'b0;
    end else if (pub_tick) begin
      count_out <= live_cnt;
      valid     <= 1'b1;
    end
  end

  a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
    evt.load |=> sync_ref_flag);
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_rise && !evt.load) |=> !sync_ref_flag);
  a_r8_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    !preset_we |=> $stable(shadow));
  a_r9_publish_only: assert property (@(posedge clk) disable iff (rst)
    !pub_tick |=> $stable(count_out));
  a_r10_invalid_zero: assert property (@(posedge clk) disable iff (rst)
    !valid |-> count_out == '0);
  a_r10_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);
endmodule

// File: tb/sim_oneshot_downcounter.sv
module sim_oneshot_downcounter;
  localparam int W    = 32;
  localparam int TICK = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic count_in = 0, sync_in = 0, en_in = 0;
  logic cfg_sync_use = 1, cfg_en_use = 1;
  logic preset_we = 0, sref_clear = 0;
  logic [W-1:0] preset_data = '0;
  logic [W-1:0] count_out;
  logic run, sync_ref_flag, valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oneshot_downcounter #(.CNT_W(W), .TICK_DIV(TICK), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .count_in(count_in), .sync_in(sync_in),
    .en_in(en_in), .cfg_sync_use(cfg_sync_use), .cfg_en_use(cfg_en_use),
    .preset_we(preset_we), .preset_data(preset_data),
    .sref_clear(sref_clear), .count_out(count_out), .run(run),
    .sync_ref_flag(sync_ref_flag), .valid(valid)
  );

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    cyc(3 * TICK);
  endtask

  task automatic pulse_cnt();
    count_in = 1; cyc(3); count_in = 0; cyc(3);
  endtask

  task automatic pulse_sync();
    sync_in = 1; cyc(3); sync_in = 0; cyc(3);
  endtask

  task automatic set_preset(input logic [W-1:0] v);
    preset_data = v; preset_we = 1; cyc(1); preset_we = 0;
  endtask

  initial begin
    cyc(1);
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rel;
    cyc(4);
    rst = 0;
    rel = 0;
    // R10: reset state
    chk("R10 valid after reset", valid, 0);
    chk("R10 count_out after reset", count_out, 0);
    chk("R5 run after reset", run, 0);
    chk("R6 flag after reset", sync_ref_flag, 0);
    // R9: first publication TICK cycles after reset release
    cyc(TICK - 3);
    chk("R9 no publish before tick", valid, 0);
    cyc(6);
    chk("R9 publish at tick", valid, 1);

    en_in = 1;
    // R1/R2/R3/R5 sweep over small presets and pulse counts
    for (int p = 1; p <= 5; p++) begin
      set_preset(W'(p));
      pulse_sync();
      settle();
      chk("R1 load preset", count_out, W'(p));
      chk("R5 run after load", run, 1);
      for (int k = 1; k <= p + 2; k++) begin
        pulse_cnt();
        settle();
        chk((k <= p) ? "R2 decrement" : "R3 parked at zero",
            count_out, (k <= p) ? W'(p - k) : '0);
        chk("R5 run tracks", run, (k < p) ? 1 : 0);
      end
    end

    // R6: flag set, cleared by command edge
    chk("R6 flag set by load", sync_ref_flag, 1);
    sref_clear = 1; cyc(2);
    chk("R6 flag cleared by edge", sync_ref_flag, 0);
    cyc(4);
    chk("R6 level does not reload", sync_ref_flag, 0);
    sref_clear = 0; cyc(2);

    // R5: preset 0 keeps run low
    set_preset('0);
    pulse_sync(); settle();
    chk("R5 zero preset run", run, 0);
    chk("R6 zero preset flag", sync_ref_flag, 1);

    // R4: enable low holds, sync still reloads
    set_preset(W'(10));
    pulse_sync(); settle();
    pulse_cnt(); settle();
    chk("R2 before hold", count_out, 9);
    en_in = 0; cyc(4);
    pulse_cnt(); pulse_cnt(); settle();
    chk("R4 held while disabled", count_out, 9);
    set_preset(W'(7));
    pulse_sync(); settle();
    chk("R4 reload while disabled", count_out, 7);
    pulse_cnt(); settle();
    chk("R4 still held after reload", count_out, 7);

    // R7: enable pin ignored when cfg_en_use=0
    cfg_en_use = 0; cyc(2);
    pulse_cnt(); settle();
    chk("R7 en pin ignored", count_out, 6);
    // R7: sync ignored when cfg_sync_use=0
    cfg_sync_use = 0;
    pulse_sync(); settle();
    chk("R7 sync ignored", count_out, 6);
    cfg_sync_use = 1; cyc(2);

    // R8: staged preset does not disturb running count
    set_preset(W'(20));
    pulse_cnt(); settle();
    chk("R8 running count kept", count_out, 5);
    pulse_sync(); settle();
    chk("R8 next load uses new preset", count_out, 20);

    // R11: simultaneous sync and count edge -> load wins
    set_preset(W'(12));
    sync_in = 1; count_in = 1; cyc(3);
    sync_in = 0; count_in = 0; cyc(3);
    settle();
    chk("R11 load wins", count_out, 12);

    // R12: full range
    set_preset('1);
    pulse_sync(); settle();
    chk("R12 max preset", count_out, 32'hFFFF_FFFF);
    pulse_cnt(); settle();
    chk("R12 max minus one", count_out, 32'hFFFF_FFFE);
    chk("R5 run at max", run, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule